// File: doc/BRIEF.md
# Combinational Sum-of-Products Logic Array

This block models a small programmable AND-OR array with no clock and no stored state. It takes ten dedicated input signals and six pin levels that come back from the bidirectional pins, and it offers each of them to the AND plane twice: once as the true level and once inverted. A flat vector of connection links selects which of these literals each of the 64 product terms uses. The terms fall into eight groups of eight, and each group serves one output pin. The first term of a group drives that pin's tri-state enable. The remaining seven terms are ORed together, and the pin's data is the inverse of that OR.

The two outer output pins, 0 and 7, are output only. Pins 1 to 6 are bidirectional. The level present on each of these six pins is fed back into the array through `pin_in`. When a pin's enable term is 0, the pin works as a plain input. When the enable term is 1, the wiring around the block must return the level the block drives, so that the pin reads back its own output.

The pin driver is split into three separate vectors: a data value, an enable, and the external level. Whatever is wired outside the block can therefore resolve each bidirectional line.

Top module: `sop_logic_array`

## Requirements
- R1: The array sees 16 signals. Signal s for s in 0..9 is `ded_in[s]`, and signal 10+k is `pin_in[k]` for bidirectional pin k+1. Column 2s carries the true level of signal s and column 2s+1 carries its inverse.
- R2: Link bit `link_cfg[t*32 + c]` set to 1 disconnects column c from product term t. A term is the AND of every column still connected to it. A term with all 32 links set evaluates to 1.
- R3: A term with all 32 links at 0 (every literal connected, an unprogrammed term) evaluates to 0 for every input pattern.
- R4: Output pin g (0..7) owns terms 8g to 8g+7. `pin_oe[g]` equals term 8g and ignores the other seven terms.
- R5: `pin_out[g]` is the inverse (active-low) of the OR of terms 8g+1 through 8g+7. Any single one of those seven terms at 1, including the last one, 8g+7, drives it to 0.
- R6: A bidirectional pin with its enable at 0 acts as an input: its `pin_in` level reaches the array whatever the enable is. `pin_in` bits that no connected term uses have no effect on any output.
- R7: With every link bit at 0 (an unprogrammed array), `pin_out` is all ones and `pin_oe` is all zeros for any input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| link_cfg | input | 2048 | Connection links, 32 per product term, with term t in bits t*32 to t*32+31; 1 means disconnected |
| ded_in | input | 10 | Dedicated input signals 0 to 9 |
| pin_in | input | 6 | Levels present on bidirectional pins 1 to 6, fed back into the array |
| pin_out | output | 8 | Active-low data value for each output pin |
| pin_oe | output | 8 | Tri-state enable for each output pin, taken from the group's first term |

## Verification
The block holds no state, so a wrong internal value is always a wrong AND-plane term, and it shows up at the ports as soon as the inputs settle. A term that is stuck or wired to the wrong column turns up as a wrong enable or data bit only for input patterns that make that term the deciding one. For that reason the vector table steers each programmed term through both of its values while the other terms stay fixed. Checks on an unprogrammed array and on an array with every link open tie down the two constant cases of the AND plane.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;
    localparam int DED_INPUTS  = 10;
    localparam int FB_PINS     = 6;
    localparam int OUT_PINS    = 8;
    localparam int GROUP_TERMS = 8;
    localparam int SIGNALS     = DED_INPUTS + FB_PINS;
    localparam int COLUMNS     = 2 * SIGNALS;
    localparam int TERMS       = OUT_PINS * GROUP_TERMS;
    localparam int LINK_BITS   = TERMS * COLUMNS;
endpackage

// File: rtl/sop_literal_cols.sv
module sop_literal_cols #(
    parameter int N_DED = 10,
    parameter int N_FB  = 6,
    localparam int N_SIG = N_DED + N_FB,
    localparam int N_COL = 2 * N_SIG
) (
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic [N_COL-1:0] cols
);
    logic [N_SIG-1:0] sig;

    // dedicated inputs occupy the low signal slots, feedback pins follow
    assign sig = {fb_in, ded_in};

    generate
        for (genvar s = 0; s < N_SIG; s++) begin : g_col
            assign cols[2*s]   = sig[s];
            assign cols[2*s+1] = ~sig[s];
        end
    endgenerate
endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane #(
    parameter int N_COL  = 32,
    parameter int N_TERM = 64,
    localparam int N_LINK = N_COL * N_TERM
) (
    input  logic [N_COL-1:0]  cols,
    input  logic [N_LINK-1:0] links,
    output logic [N_TERM-1:0] terms
);
    // an open link forces its column to 1 so it drops out of the AND
    generate
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            assign terms[t] = &(cols | links[t*N_COL +: N_COL]);
        end
    endgenerate

    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            if (links[t*N_COL +: N_COL] == '0) begin
                assert_fully_connected_low_R3: assert (terms[t] == 1'b0)
                    else $error("term %0d high with all literals connected", t);
            end
            if (links[t*N_COL +: N_COL] == '1) begin
                assert_open_term_high_R2: assert (terms[t] == 1'b1)
                    else $error("term %0d low with all literals open", t);
            end
        end
    end
endmodule

// File: rtl/sop_output_cell.sv
module sop_output_cell #(
    parameter int N_GRP = 8
) (
    input  logic [N_GRP-1:0] grp_terms,
    output logic             pin_drive,
    output logic             pin_en
);
    logic sum_hit;

    assign pin_en    = grp_terms[0];
    assign sum_hit   = |grp_terms[N_GRP-1:1];
    assign pin_drive = ~sum_hit;
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
    import sop_array_pkg::*;
(
    input  logic [LINK_BITS-1:0]  link_cfg,
    input  logic [DED_INPUTS-1:0] ded_in,
    input  logic [FB_PINS-1:0]    pin_in,
    output logic [OUT_PINS-1:0]   pin_out,
    output logic [OUT_PINS-1:0]   pin_oe
);
    localparam int GROUP_LINKS = GROUP_TERMS * COLUMNS;

    logic [COLUMNS-1:0] cols;
    logic [TERMS-1:0]   terms;

    sop_literal_cols #(
        .N_DED(DED_INPUTS),
        .N_FB (FB_PINS)
    ) u_cols (
        .ded_in(ded_in),
        .fb_in (pin_in),
        .cols  (cols)
    );

    sop_term_plane #(
        .N_COL (COLUMNS),
        .N_TERM(TERMS)
    ) u_plane (
        .cols (cols),
        .links(link_cfg),
        .terms(terms)
    );

    generate
        for (genvar g = 0; g < OUT_PINS; g++) begin : g_out
            sop_output_cell #(
                .N_GRP(GROUP_TERMS)
            ) u_cell (
                .grp_terms(terms[g*GROUP_TERMS +: GROUP_TERMS]),
                .pin_drive(pin_out[g]),
                .pin_en   (pin_oe[g])
            );
        end
    endgenerate

    always_comb begin
        for (int g = 0; g < OUT_PINS; g++) begin
            if (link_cfg[g*GROUP_LINKS +: COLUMNS] == '1) begin
                assert_enable_follows_term_R4: assert (pin_oe[g] == 1'b1)
                    else $error("pin %0d disabled with open enable term", g);
            end
            for (int k = 1; k < GROUP_TERMS; k++) begin
                if (link_cfg[g*GROUP_LINKS + k*COLUMNS +: COLUMNS] == '1) begin
                    assert_any_term_pulls_low_R5: assert (pin_out[g] == 1'b0)
                        else $error("pin %0d high with data term %0d open", g, k);
                end
            end
            if (link_cfg[g*GROUP_LINKS +: GROUP_LINKS] == '0) begin
                assert_blank_group_idle_R7: assert (pin_out[g] && !pin_oe[g])
                    else $error("pin %0d active with blank group", g);
            end
        end
    end
endmodule

// File: tb/sop_logic_array_test.sv
module sop_logic_array_test;
    import sop_array_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [9:0] d;
        logic [5:0] p;
        logic [7:0] exp_out;
        logic [7:0] exp_oe;
    } vec_t;

    // expected values worked out by hand from the test programming below
    localparam vec_t VECS [6] = '{
        '{10'h000, 6'h00, 8'hD6, 8'h1B},
        '{10'h3FF, 6'h3F, 8'h64, 8'hB9},
        '{10'h005, 6'h01, 8'hD7, 8'h1B},
        '{10'h027, 6'h01, 8'h56, 8'h1B},
        '{10'h3FF, 6'h00, 8'hC4, 8'hB9},
        '{10'h298, 6'h20, 8'hF4, 8'hB9}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LINK_BITS-1:0]  link_cfg = '0;
    logic [DED_INPUTS-1:0] ded_in = '0;
    logic [FB_PINS-1:0]    pin_in = '0;
    logic [OUT_PINS-1:0]   pin_out;
    logic [OUT_PINS-1:0]   pin_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_logic_array uut (
        .link_cfg(link_cfg),
        .ded_in  (ded_in),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // connect only the columns set in keep; everything else open
    task automatic put_term(input int t, input logic [31:0] keep);
        link_cfg[t*COLUMNS +: COLUMNS] = ~keep;
    endtask

    task automatic apply(input logic [9:0] d, input logic [5:0] p);
        ded_in = d;
        pin_in = p;
        @(negedge clk);
    endtask

    task automatic load_test_program();
        link_cfg = '0;
        put_term(0,  32'h0000_0000);      // pin 0 always enabled
        put_term(1,  32'h0000_0005);      // I0 & I1
        put_term(2,  32'h0000_0020);      // ~I2
        put_term(8,  32'h0008_0000);      // pin 1 enable: ~I9
        put_term(9,  32'h0000_0040);      // I3
        for (int t = 24; t < 32; t++) put_term(t, 32'h0); // pin 3 all open
        put_term(32, 32'h0000_0000);      // pin 4 enabled
        put_term(39, 32'h0000_1000);      // last data term: I6
        put_term(40, 32'h0000_4000);      // pin 5 enable: I7
        put_term(41, 32'h8000_0000);      // ~feedback of pin 6
        put_term(56, 32'h0000_0100);      // pin 7 enable: I4
        put_term(57, 32'h0010_0400);      // feedback of pin 1 & I5
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 / R3: unprogrammed array after start-up
        apply(10'h000, 6'h00);
        check8("R7 blank out, inputs low", pin_out, 8'hFF);
        check8("R7 blank oe, inputs low", pin_oe, 8'h00);
        apply(10'h3FF, 6'h3F);
        check8("R3 blank out, inputs high", pin_out, 8'hFF);
        check8("R3 blank oe, inputs high", pin_oe, 8'h00);

        // R2: every link open, every term is 1
        link_cfg = '1;
        apply(10'h155, 6'h2A);
        check8("R2 open array out", pin_out, 8'h00);
        check8("R2 open array oe", pin_oe, 8'hFF);

        // R1 / R4 / R5: vector table against the test program
        load_test_program();
        foreach (VECS[i]) begin
            apply(VECS[i].d, VECS[i].p);
            check8($sformatf("R1 R5 vector %0d out", i), pin_out, VECS[i].exp_out);
            check8($sformatf("R4 vector %0d oe", i), pin_oe, VECS[i].exp_oe);
        end

        // R6: pin 1 disabled (I9 high) still feeds pin 7 through the array
        apply(10'h220, 6'h01);
        check8("R6 disabled pin read high out", pin_out, 8'h56);
        check8("R6 disabled pin read high oe", pin_oe, 8'h19);
        apply(10'h220, 6'h00);
        check8("R6 disabled pin read low out", pin_out, 8'hD6);
        apply(10'h220, 6'h1E);
        check8("R6 unused feedback ignored out", pin_out, 8'hD6);
        check8("R6 unused feedback ignored oe", pin_oe, 8'h19);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule